// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block holds two banks of address translation windows, one for traffic arriving from the link side (inbound) and one for traffic leaving toward it (outbound). Software never addresses a window directly. It first writes a selector register that names a direction and a window number. All the per-window registers then read and write that window. Each window carries a 64-bit base, a 32-bit limit, a 64-bit target and two 32-bit control words. The first control word sets the window type (memory or configuration). Bit 31 of the second one enables the window.

Programming is staged. Writes to base, limit, target and the type word land in shadow registers only. The lookup datapath changes only when the second control word is written, and that write commits the whole window at once. A lookup presents an address and a direction. One cycle later the block reports whether an enabled window of that direction covers the address. For a memory window it returns the translated address. For a configuration window it returns the bus number, device/function number and register offset taken from the window's target and the offset into the window.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF, type word 0 and enable word 0. The exception is inbound window 0, whose enable word reads 0x80000000, so an inbound lookup of any address up to 0xFFFFFFFF hits window 0 and comes back unchanged. No result is valid before the first lookup.
- R2: The selector sits at offset 0x900. Bit 31 = 1 picks the inbound bank and 0 the outbound bank, and bits [IDX_W-1:0] pick the window. A write keeps only bit 31 and those index bits, and a read returns the kept value.
- R3: The selected window's registers are: 0x904 type word, 0x908 enable word, 0x90C/0x910 base low/high half, 0x914 limit, 0x918/0x91C target low/high half. A half write changes only its own 32 bits. Any other offset reads 0, and a write to it has no effect.
- R4: Writes to base, limit, target or the type word do not change lookup results. A write to the enable word commits the window's shadow base, limit, target and type, together with the new enable bit 31.
- R5: A committed window hits an address when it is enabled and base <= address <= limit (limit zero-extended to 64 bits). A disabled window never hits.
- R6: A memory window (type word 0) maps a hit address to target + (address - base), modulo 2^64.
- R7: A window whose type word is nonzero is a configuration window. A hit in it flags rs_cfg. It returns bus = target[31:24], devfn = target[23:16] and offset = (address - base) mod CFG_BYTES, and it leaves rs_addr equal to the address.
- R8: When several enabled windows of the selected direction hit, the lowest-numbered one is reported and used.
- R9: On a miss, rs_hit and rs_cfg are 0, rs_addr equals the looked-up address, and rs_win, rs_bus, rs_devfn and rs_off are 0.
- R10: rs_valid is high exactly one cycle after lk_valid. Only windows of the direction named by lk_inbound take part in a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_valid | input | 1 | Lookup request |
| lk_inbound | input | 1 | Lookup direction: 1 inbound, 0 outbound |
| lk_addr | input | 64 | Address to look up |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Some enabled window covered the address |
| rs_cfg | output | 1 | Hit window is a configuration window |
| rs_win | output | IDX_W | Number of the hit window |
| rs_addr | output | 64 | Translated address, or the input address |
| rs_bus | output | 8 | Configuration bus number |
| rs_devfn | output | 8 | Configuration device/function number |
| rs_off | output | OFF_W | Configuration register offset |

## Verification
The assertions assume several things about the inputs. NUM_WIN and CFG_BYTES are powers of two. At most one register write occurs per cycle. lk_inbound and lk_addr are known whenever lk_valid is high. They also assume that a lookup made in the same cycle as an enable-word write sees the windows as they stood before that write. The stimulus drives writes and lookups in separate cycles and changes all inputs on the falling clock edge. It programs overlapping windows in both banks only after reset, so every expected result follows from committed state alone.

// File: rtl/xwu_pkg.sv
package xwu_pkg;

  localparam logic [11:0] OFS_SEL   = 12'h900;
  localparam logic [11:0] OFS_TYPE  = 12'h904;
  localparam logic [11:0] OFS_ENA   = 12'h908;
  localparam logic [11:0] OFS_BLO   = 12'h90C;
  localparam logic [11:0] OFS_BHI   = 12'h910;
  localparam logic [11:0] OFS_LIM   = 12'h914;
  localparam logic [11:0] OFS_TLO   = 12'h918;
  localparam logic [11:0] OFS_THI   = 12'h91C;

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] limit;
    logic [63:0] target;
    logic        is_cfg;
    logic        en;
  } xwu_win_t;

  function automatic logic win_covers(xwu_win_t w, logic [63:0] a);
    return w.en && (a >= w.base) && (a <= {32'd0, w.limit});
  endfunction

  function automatic logic [63:0] mem_xlat(xwu_win_t w, logic [63:0] a);
    return w.target + (a - w.base);
  endfunction

endpackage

// File: rtl/xwu_regfile.sv
module xwu_regfile
  import xwu_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output xwu_win_t    act_in_o  [NUM_WIN],
  output xwu_win_t    act_out_o [NUM_WIN],
  output logic        commit_evt_o
);

  localparam logic [31:0] SEL_KEEP = 32'h8000_0000 | 32'(NUM_WIN - 1);

  logic [31:0] sel_q;
  logic [63:0] sh_base [2][NUM_WIN];
  logic [31:0] sh_lim  [2][NUM_WIN];
  logic [63:0] sh_tgt  [2][NUM_WIN];
  logic [31:0] sh_type [2][NUM_WIN];
  logic [31:0] sh_ena  [2][NUM_WIN];
  xwu_win_t    act     [2][NUM_WIN];

  logic             sd;
  logic [IDX_W-1:0] si;
  assign sd = sel_q[31];
  assign si = sel_q[IDX_W-1:0];

  assign commit_evt_o = reg_we && (reg_addr == OFS_ENA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          sh_base[d][w] <= '0;
          sh_lim[d][w]  <= 32'hFFFF_FFFF;
          sh_tgt[d][w]  <= '0;
          sh_type[d][w] <= '0;
          sh_ena[d][w]  <= '0;
          act[d][w]     <= '{base: 64'd0, limit: 32'hFFFF_FFFF, target: 64'd0,
                             is_cfg: 1'b0, en: 1'b0};
        end
      end
      sh_ena[1][0] <= 32'h8000_0000;
      act[1][0].en <= 1'b1;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_SEL:  sel_q <= reg_wdata & SEL_KEEP;
        OFS_TYPE: sh_type[sd][si] <= reg_wdata;
        OFS_ENA: begin
          sh_ena[sd][si] <= reg_wdata;
          act[sd][si]    <= '{base: sh_base[sd][si], limit: sh_lim[sd][si],
                              target: sh_tgt[sd][si],
                              is_cfg: (sh_type[sd][si] != 32'd0),
                              en: reg_wdata[31]};
        end
        OFS_BLO:  sh_base[sd][si][31:0]  <= reg_wdata;
        OFS_BHI:  sh_base[sd][si][63:32] <= reg_wdata;
        OFS_LIM:  sh_lim[sd][si]         <= reg_wdata;
        OFS_TLO:  sh_tgt[sd][si][31:0]   <= reg_wdata;
        OFS_THI:  sh_tgt[sd][si][63:32]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_SEL:  reg_rdata = sel_q;
      OFS_TYPE: reg_rdata = sh_type[sd][si];
      OFS_ENA:  reg_rdata = sh_ena[sd][si];
      OFS_BLO:  reg_rdata = sh_base[sd][si][31:0];
      OFS_BHI:  reg_rdata = sh_base[sd][si][63:32];
      OFS_LIM:  reg_rdata = sh_lim[sd][si];
      OFS_TLO:  reg_rdata = sh_tgt[sd][si][31:0];
      OFS_THI:  reg_rdata = sh_tgt[sd][si][63:32];
      default:  reg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
    assign act_in_o[g]  = act[1][g];
    assign act_out_o[g] = act[0][g];
  end

endmodule

// File: rtl/xwu_match.sv
module xwu_match
  import xwu_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  xwu_win_t         win_i [NUM_WIN],
  input  logic [63:0]      addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NUM_WIN-1:0] cov;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cov
    assign cov[g] = win_covers(win_i[g], addr_i);
  end

  always_comb begin
    hit_o = |cov;
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (cov[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
  import xwu_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int CFG_BYTES = 4096,
  localparam int IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int OFF_W    = $clog2(CFG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             lk_valid,
  input  logic             lk_inbound,
  input  logic [63:0]      lk_addr,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_cfg,
  output logic [IDX_W-1:0] rs_win,
  output logic [63:0]      rs_addr,
  output logic [7:0]       rs_bus,
  output logic [7:0]       rs_devfn,
  output logic [OFF_W-1:0] rs_off
);

  localparam int WB = $bits(xwu_win_t);

  xwu_win_t act_in  [NUM_WIN];
  xwu_win_t act_out [NUM_WIN];
  logic     commit_evt;

  xwu_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .act_in_o     (act_in),
    .act_out_o    (act_out),
    .commit_evt_o (commit_evt)
  );

  logic             hit_in, hit_out;
  logic [IDX_W-1:0] idx_in, idx_out;

  xwu_match #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) match_in_i (
    .win_i (act_in), .addr_i (lk_addr), .hit_o (hit_in), .idx_o (idx_in)
  );

  xwu_match #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) match_out_i (
    .win_i (act_out), .addr_i (lk_addr), .hit_o (hit_out), .idx_o (idx_out)
  );

  function automatic logic [OFF_W-1:0] cfg_offset(xwu_win_t w, logic [63:0] a);
    return OFF_W'(a - w.base);
  endfunction

  // Observation wires for the checker
  logic [NUM_WIN-1:0]       en_in_vec, en_out_vec;
  logic [2*NUM_WIN*WB-1:0]  act_flat;
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_obs
    assign en_in_vec[g]  = act_in[g].en;
    assign en_out_vec[g] = act_out[g].en;
    assign act_flat[g*2*WB +: 2*WB] = {act_in[g], act_out[g]};
  end

  logic             n_hit, n_cfg;
  logic [IDX_W-1:0] n_win;
  logic [63:0]      n_addr;
  logic [7:0]       n_bus, n_devfn;
  logic [OFF_W-1:0] n_off;

  always_comb begin
    n_hit   = lk_inbound ? hit_in : hit_out;
    n_win   = '0;
    n_cfg   = 1'b0;
    n_addr  = lk_addr;
    n_bus   = '0;
    n_devfn = '0;
    n_off   = '0;
    if (n_hit) begin
      n_win = lk_inbound ? idx_in : idx_out;
      if (lk_inbound ? act_in[idx_in].is_cfg : act_out[idx_out].is_cfg) begin
        n_cfg = 1'b1;
        if (lk_inbound) begin
          n_bus   = act_in[idx_in].target[31:24];
          n_devfn = act_in[idx_in].target[23:16];
          n_off   = cfg_offset(act_in[idx_in], lk_addr);
        end else begin
          n_bus   = act_out[idx_out].target[31:24];
          n_devfn = act_out[idx_out].target[23:16];
          n_off   = cfg_offset(act_out[idx_out], lk_addr);
        end
      end else begin
        n_addr = lk_inbound ? mem_xlat(act_in[idx_in], lk_addr)
                            : mem_xlat(act_out[idx_out], lk_addr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_cfg   <= 1'b0;
      rs_win   <= '0;
      rs_addr  <= '0;
      rs_bus   <= '0;
      rs_devfn <= '0;
      rs_off   <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= n_hit;
      rs_cfg   <= n_cfg;
      rs_win   <= n_win;
      rs_addr  <= n_addr;
      rs_bus   <= n_bus;
      rs_devfn <= n_devfn;
      rs_off   <= n_off;
    end
  end

endmodule

// File: rtl/xwu_checker.sv
module xwu_checker #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2,
  parameter int OFF_W   = 12,
  parameter int FLAT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              lk_valid,
  input logic              lk_inbound,
  input logic [63:0]       lk_addr,
  input logic              rs_valid,
  input logic              rs_hit,
  input logic              rs_cfg,
  input logic [IDX_W-1:0]  rs_win,
  input logic [63:0]       rs_addr,
  input logic [7:0]        rs_bus,
  input logic [7:0]        rs_devfn,
  input logic [OFF_W-1:0]  rs_off,
  input logic              commit_evt,
  input logic [NUM_WIN-1:0] en_in_vec,
  input logic [NUM_WIN-1:0] en_out_vec,
  input logic [FLAT_W-1:0] act_flat
);

  localparam logic [31:0] KEEP = 32'h8000_0000 | 32'(NUM_WIN - 1);

  logic [NUM_WIN-1:0] en_sel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_sel_q <= '0;
    else        en_sel_q <= lk_inbound ? en_in_vec : en_out_vec;
  end

  AST_SEL_KEPT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h900) |=>
      ((reg_addr != 12'h900) || (reg_rdata == ($past(reg_wdata) & KEEP)))); // R2

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid); // R10

  AST_NO_RESULT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid); // R10

  AST_MISS_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |->
      (rs_addr == $past(lk_addr) && !rs_cfg && rs_win == '0 &&
       rs_bus == 8'd0 && rs_devfn == 8'd0 && rs_off == '0)); // R9

  AST_CFG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_cfg) |-> (rs_hit && rs_addr == $past(lk_addr))); // R7

  AST_HIT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> en_sel_q[rs_win]); // R5

  AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(act_flat)); // R4

endmodule

bind xlat_window_unit xwu_checker #(
  .NUM_WIN (NUM_WIN),
  .IDX_W   (IDX_W),
  .OFF_W   (OFF_W),
  .FLAT_W  (2*NUM_WIN*WB)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .lk_valid   (lk_valid),
  .lk_inbound (lk_inbound),
  .lk_addr    (lk_addr),
  .rs_valid   (rs_valid),
  .rs_hit     (rs_hit),
  .rs_cfg     (rs_cfg),
  .rs_win     (rs_win),
  .rs_addr    (rs_addr),
  .rs_bus     (rs_bus),
  .rs_devfn   (rs_devfn),
  .rs_off     (rs_off),
  .commit_evt (commit_evt),
  .en_in_vec  (en_in_vec),
  .en_out_vec (en_out_vec),
  .act_flat   (act_flat)
);

// File: tb/xlat_window_unit_tb_top.sv
module xlat_window_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_inbound = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        rs_valid, rs_hit, rs_cfg;
  logic [1:0]  rs_win;
  logic [63:0] rs_addr;
  logic [7:0]  rs_bus, rs_devfn;
  logic [11:0] rs_off;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  xlat_window_unit dut_i (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .lk_valid (lk_valid),
    .lk_inbound (lk_inbound), .lk_addr (lk_addr), .rs_valid (rs_valid),
    .rs_hit (rs_hit), .rs_cfg (rs_cfg), .rs_win (rs_win), .rs_addr (rs_addr),
    .rs_bus (rs_bus), .rs_devfn (rs_devfn), .rs_off (rs_off)
  );

  typedef struct packed {
    logic        inb;
    logic [63:0] addr;
    logic        hit;
    logic        cfg;
    logic [1:0]  win;
    logic [63:0] xaddr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
  } vec_t;

  // Expected results after the programming phase (see initial block)
  localparam vec_t VECS [12] = '{
    '{1'b0, 64'h0000_0000_1000_0000, 1'b1, 1'b0, 2'd0, 64'h0000_0002_0000_0000, 8'h00, 8'h00, 12'h000},
    '{1'b0, 64'h0000_0000_1000_FFFF, 1'b1, 1'b0, 2'd0, 64'h0000_0002_0000_FFFF, 8'h00, 8'h00, 12'h000},
    '{1'b0, 64'h0000_0000_1000_8004, 1'b1, 1'b0, 2'd0, 64'h0000_0002_0000_8004, 8'h00, 8'h00, 12'h000},
    '{1'b0, 64'h0000_0000_1001_0000, 1'b1, 1'b1, 2'd1, 64'h0000_0000_1001_0000, 8'h05, 8'h18, 12'h000},
    '{1'b0, 64'h0000_0000_1001_0ABC, 1'b1, 1'b1, 2'd1, 64'h0000_0000_1001_0ABC, 8'h05, 8'h18, 12'hABC},
    '{1'b0, 64'h0000_0000_1001_FFFF, 1'b1, 1'b1, 2'd1, 64'h0000_0000_1001_FFFF, 8'h05, 8'h18, 12'hFFF},
    '{1'b0, 64'h0000_0000_1002_0000, 1'b0, 1'b0, 2'd0, 64'h0000_0000_1002_0000, 8'h00, 8'h00, 12'h000},
    '{1'b0, 64'h0000_0000_0FFF_FFFF, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0FFF_FFFF, 8'h00, 8'h00, 12'h000},
    '{1'b0, 64'h0000_0000_2000_0010, 1'b0, 1'b0, 2'd0, 64'h0000_0000_2000_0010, 8'h00, 8'h00, 12'h000},
    '{1'b1, 64'h0000_0000_1234_5678, 1'b1, 1'b0, 2'd0, 64'h0000_0000_1234_5678, 8'h00, 8'h00, 12'h000},
    '{1'b1, 64'h0000_0000_4000_0010, 1'b1, 1'b0, 2'd0, 64'h0000_0000_4000_0010, 8'h00, 8'h00, 12'h000},
    '{1'b1, 64'h0000_0001_0000_0000, 1'b0, 1'b0, 2'd0, 64'h0000_0001_0000_0000, 8'h00, 8'h00, 12'h000}
  };

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%03h actual 0x%08h expected 0x%08h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic look(input vec_t v, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_inbound = v.inb; lk_addr = v.addr;
    @(negedge clk);
    lk_valid = 1'b0;
    checks++;
    if (rs_valid !== 1'b1 || rs_hit !== v.hit || rs_cfg !== v.cfg || rs_win !== v.win ||
        rs_addr !== v.xaddr || rs_bus !== v.bus || rs_devfn !== v.devfn || rs_off !== v.off) begin
      errors++;
      $display("FAIL %s: addr 0x%016h actual v%0b h%0b c%0b w%0d a%016h b%02h d%02h o%03h expected v1 h%0b c%0b w%0d a%016h b%02h d%02h o%03h",
               req, v.addr, rs_valid, rs_hit, rs_cfg, rs_win, rs_addr, rs_bus, rs_devfn, rs_off,
               v.hit, v.cfg, v.win, v.xaddr, v.bus, v.devfn, v.off);
    end
  endtask

  function automatic vec_t mk(input logic inb, input logic [63:0] a, input logic hit,
                              input logic [1:0] w, input logic [63:0] xa);
    return '{inb, a, hit, 1'b0, w, xa, 8'h00, 8'h00, 12'h000};
  endfunction

  task automatic prog(input logic [31:0] sel, input logic [31:0] blo, input logic [31:0] lim,
                      input logic [31:0] tlo, input logic [31:0] thi,
                      input logic [31:0] typ, input logic [31:0] ena);
    wr(12'h900, sel);
    wr(12'h90C, blo);
    wr(12'h910, 32'h0);
    wr(12'h914, lim);
    wr(12'h918, tlo);
    wr(12'h91C, thi);
    wr(12'h904, typ);
    wr(12'h908, ena);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    checks++;
    if (rs_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rs_valid actual %0b expected 0", rs_valid);
    end
    rd_chk(12'h900, 32'h0, "R1");
    rd_chk(12'h908, 32'h0, "R1");
    rd_chk(12'h914, 32'hFFFF_FFFF, "R1");
    rd_chk(12'h90C, 32'h0, "R1");
    rd_chk(12'h91C, 32'h0, "R1");
    rd_chk(12'h904, 32'h0, "R1");
    wr(12'h900, 32'h8000_0000);
    rd_chk(12'h908, 32'h8000_0000, "R1");
    wr(12'h900, 32'h8000_0001);
    rd_chk(12'h908, 32'h0, "R1");
    look(mk(1'b1, 64'h0000_0000_ABCD_0000, 1'b1, 2'd0, 64'h0000_0000_ABCD_0000), "R1");
    look(mk(1'b0, 64'h0000_0000_0000_0010, 1'b0, 2'd0, 64'h0000_0000_0000_0010), "R10");

    // Programming: outbound 0 memory, outbound 1 config overlapping, outbound 3 disabled,
    // inbound 2 memory overlapping reset-enabled inbound 0
    prog(32'h0000_0000, 32'h1000_0000, 32'h1000_FFFF, 32'h0, 32'h2, 32'h0, 32'h8000_0000);
    prog(32'h0000_0001, 32'h1000_8000, 32'h1001_FFFF, 32'h0518_0000, 32'h0, 32'h4, 32'h8000_0000);
    prog(32'h0000_0003, 32'h2000_0000, 32'h2000_0FFF, 32'h0, 32'hABCD, 32'h0, 32'h0);
    prog(32'h8000_0002, 32'h4000_0000, 32'h4FFF_FFFF, 32'h8000_0000, 32'h0, 32'h0, 32'h8000_0000);

    // Table walk: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 12; i++) begin
      look(VECS[i], "R5/R6/R7/R8/R9");
    end

    // R3: half writes, unmapped offsets
    wr(12'h900, 32'h0000_0000);
    rd_chk(12'h91C, 32'h0000_0002, "R3");
    wr(12'h918, 32'h0000_1111);
    rd_chk(12'h91C, 32'h0000_0002, "R3");
    rd_chk(12'h918, 32'h0000_1111, "R3");
    wr(12'h920, 32'hFFFF_FFFF);
    rd_chk(12'h920, 32'h0, "R3");
    rd_chk(12'h900, 32'h0, "R3");
    rd_chk(12'h914, 32'h1000_FFFF, "R3");

    // R4: staged writes do not affect lookups until the enable word is written
    wr(12'h90C, 32'h3000_0000);
    look(mk(1'b0, 64'h0000_0000_1000_0010, 1'b1, 2'd0, 64'h0000_0002_0000_0010), "R4");
    rd_chk(12'h90C, 32'h3000_0000, "R4");
    wr(12'h914, 32'h3000_00FF);
    look(mk(1'b0, 64'h0000_0000_3000_0004, 1'b0, 2'd0, 64'h0000_0000_3000_0004), "R4");
    wr(12'h908, 32'h8000_0000);
    look(mk(1'b0, 64'h0000_0000_3000_0004, 1'b1, 2'd0, 64'h0000_0002_0000_1115), "R4");
    look(mk(1'b0, 64'h0000_0000_1000_0010, 1'b0, 2'd0, 64'h0000_0000_1000_0010), "R4");

    // R5 R8: disabling inbound 0 exposes inbound 2
    wr(12'h900, 32'h8000_0000);
    wr(12'h908, 32'h0);
    rd_chk(12'h908, 32'h0, "R5");
    look(mk(1'b1, 64'h0000_0000_4000_0010, 1'b1, 2'd2, 64'h0000_0000_8000_0010), "R8");
    look(mk(1'b1, 64'h0000_0000_1234_5678, 1'b0, 2'd0, 64'h0000_0000_1234_5678), "R5");

    // R2: selector masking
    wr(12'h900, 32'hFFFF_FFFF);
    rd_chk(12'h900, 32'h8000_0003, "R2");
    rd_chk(12'h914, 32'hFFFF_FFFF, "R2");
    wr(12'h900, 32'h7FFF_FFFE);
    rd_chk(12'h900, 32'h0000_0002, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule